// File: doc/BRIEF.md
# Conditional skip sequencing unit

This unit decides, one instruction slot at a time, whether the instruction now in the execute slot of a small 8-bit core is to be annulled. Four instruction classes can open a skip: decrement-and-skip-if-zero, increment-and-skip-if-zero, skip-if-bit-clear and skip-if-bit-set. The decoder supplies each slot's class. The datapath supplies the zero flag of the updated register and the tested bit. When the condition of a live skip instruction is met, the unit annuls the next valid slot.

A page-select or bank-select word does not end the skip. The unit annuls every such prefix word that follows a taken skip, and also the first ordinary word after them. A guarded page change plus jump therefore vanishes as one unit. Annulled prefix words never raise their write enables, so the page and bank state stay untouched. Each taken or untaken skip reports its cost in cycles. That cost is the skip instruction plus one per annulled word, and it is given as a one-cycle done pulse with the length alongside.

Top module: `skip_seq`

## Requirements
- R1: A live slot of class 1 (decrement-skip) or class 2 (increment-skip) with `res_zero` high is a taken skip: `busy` is high in the following cycle and the next valid slot is annulled.
- R2: A live slot of class 3 is taken when `bit_val` is 0, and a live slot of class 4 is taken when `bit_val` is 1.
- R3: An untaken skip annuls nothing. The next valid slot has `annul` low, and one cycle after the skip slot `skip_done` pulses with `skip_len` equal to 1.
- R4: A taken skip followed by an ordinary word (class 0) annuls exactly that word and no later one. `skip_done` pulses the cycle after the annulled word, with `skip_len` equal to 2.
- R5: A taken skip followed by k prefix words (class 5 page-select, class 6 bank-select, in any mix) annuls all k of them plus the next non-prefix word, and reports `skip_len` equal to k+2.
- R6: `page_we` is high only for a valid, non-annulled class-5 slot, and `bank_we` only for a valid, non-annulled class-6 slot.
- R7: Cycles with `slot_vld` low neither annul, count, nor change `busy`. A pending skip waits through them.
- R8: Reset clears the pending skip: `busy`, `annul`, `skip_done` and `skip_len` are 0 after reset.
- R9: `skip_len` saturates at 2^CNT_W-1 for long prefix chains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_vld | input | 1 | An instruction occupies the execute slot |
| slot_cls | input | CLS_W | Class of the slot: 0 plain, 1 dec-skip, 2 inc-skip, 3 skip-if-clear, 4 skip-if-set, 5 page-select, 6 bank-select |
| res_zero | input | 1 | Updated register value is zero |
| bit_val | input | 1 | Value of the tested bit |
| annul | output | 1 | Current slot is suppressed |
| page_we | output | 1 | Page state may be written this slot |
| bank_we | output | 1 | Bank state may be written this slot |
| busy | output | 1 | A taken skip is pending |
| skip_done | output | 1 | One-cycle pulse: a skip has finished |
| skip_len | output | CNT_W | Cycles consumed by the finished skip |

## Verification
A stuck or lost pending state shows at once on the next valid slot. Either `annul` rises where it must not, or it stays low where a word should vanish, and a prefix word then raises its write enable. A pending state that ends too early or too late shows as a wrong `skip_len` in the cycle after the chain's last annulled word. The sweep covers every skip class, both conditions, prefix chains of length 0 to 3, and bubbles, so each of these shows within a few cycles of its cause.

// File: rtl/skip_seq.sv
module skip_seq #(
  parameter int CLS_W = 3,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slot_vld,
  input  logic [CLS_W-1:0] slot_cls,
  input  logic             res_zero,
  input  logic             bit_val,
  output logic             annul,
  output logic             page_we,
  output logic             bank_we,
  output logic             busy,
  output logic             skip_done,
  output logic [CNT_W-1:0] skip_len
);
  localparam logic [CLS_W-1:0] C_DEC  = CLS_W'(1);
  localparam logic [CLS_W-1:0] C_INC  = CLS_W'(2);
  localparam logic [CLS_W-1:0] C_CLR  = CLS_W'(3);
  localparam logic [CLS_W-1:0] C_SET  = CLS_W'(4);
  localparam logic [CLS_W-1:0] C_PAGE = CLS_W'(5);
  localparam logic [CLS_W-1:0] C_BANK = CLS_W'(6);
  localparam logic [CNT_W-1:0] LEN_MAX = '1;
  localparam logic [CNT_W-1:0] LEN_ONE = CNT_W'(1);

  logic             pend;
  logic [CNT_W-1:0] cnt;

  wire is_zsk  = (slot_cls == C_DEC) || (slot_cls == C_INC);
  wire is_bsk  = (slot_cls == C_CLR) || (slot_cls == C_SET);
  wire is_skip = is_zsk || is_bsk;
  wire is_pfx  = (slot_cls == C_PAGE) || (slot_cls == C_BANK);
  wire cond    = (is_zsk && res_zero) ||
                 ((slot_cls == C_CLR) && !bit_val) ||
                 ((slot_cls == C_SET) && bit_val);
  wire live    = slot_vld && !pend;
  wire take    = live && is_skip && cond;
  wire [CNT_W-1:0] cnt_nx = (cnt == LEN_MAX) ? cnt : cnt + LEN_ONE;

  assign annul   = slot_vld && pend;
  assign busy    = pend;
  assign page_we = live && (slot_cls == C_PAGE);
  assign bank_we = live && (slot_cls == C_BANK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend      <= 1'b0;
      cnt       <= '0;
      skip_done <= 1'b0;
      skip_len  <= '0;
    end else begin
      skip_done <= 1'b0;
      if (take) begin
        pend <= 1'b1;
        cnt  <= LEN_ONE;
      end else if (live && is_skip) begin
        skip_done <= 1'b1;
        skip_len  <= LEN_ONE;
      end else if (annul) begin
        cnt <= cnt_nx;
        if (!is_pfx) begin
          pend      <= 1'b0;
          skip_done <= 1'b1;
          skip_len  <= cnt_nx;
        end
      end
    end
  end

  a_r1_taken_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_vld && !annul && is_zsk && res_zero) |=> busy);
  a_r3_untaken_len1: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_vld && !annul && is_skip && !cond) |=> (!busy && skip_done && skip_len == LEN_ONE));
  a_r5_chain_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (annul && is_pfx) |=> busy);
  a_r4_chain_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (annul && !is_pfx) |=> (!busy && skip_done));
  a_r7_bubble_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_vld |=> $stable(busy));
  a_r6_we_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({annul, page_we, bank_we}));
endmodule

// File: tb/skip_seq_tb.sv
`timescale 1ns/1ps
module skip_seq_tb_top;
  localparam int CNT_W = 4;
  localparam int LMAX = (1 << CNT_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic slot_vld = 1'b0, res_zero = 1'b0, bit_val = 1'b0;
  logic [2:0] slot_cls = '0;
  logic annul, page_we, bank_we, busy, skip_done;
  logic [CNT_W-1:0] skip_len;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  skip_seq #(.CLS_W(3), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .slot_vld(slot_vld), .slot_cls(slot_cls),
    .res_zero(res_zero), .bit_val(bit_val), .annul(annul),
    .page_we(page_we), .bank_we(bank_we), .busy(busy),
    .skip_done(skip_done), .skip_len(skip_len));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic slot(input logic [2:0] c, input logic rz, input logic bv,
                      input logic exp_an, input string req);
    @(negedge clk);
    slot_vld = 1'b1; slot_cls = c; res_zero = rz; bit_val = bv;
    #1;
    chk({req, " annul"}, annul, exp_an);
    chk("R6 page_we", page_we, (c == 3'd5) && !exp_an);
    chk("R6 bank_we", bank_we, (c == 3'd6) && !exp_an);
  endtask

  task automatic bubble(input logic exp_busy);
    @(negedge clk);
    slot_vld = 1'b0; slot_cls = 3'd0;
    #1;
    chk("R7 bubble annul", annul, 0);
    chk("R7 bubble busy", busy, exp_busy);
  endtask

  task automatic done_chk(input int exp_len, input string req);
    @(negedge clk);
    slot_vld = 1'b0; slot_cls = 3'd0;
    #1;
    chk({req, " skip_done"}, skip_done, 1);
    chk({req, " skip_len"}, skip_len, exp_len);
    chk({req, " busy"}, busy, 0);
  endtask

  task automatic run(input int sc, input logic cv, input int k, input logic bub);
    logic rz, bv, taken;
    int exp_len;
    rz = 1'b0; bv = 1'b0;
    if (sc <= 2) rz = cv;
    else if (sc == 3) bv = !cv;
    else bv = cv;
    taken = cv;
    slot(3'(sc), rz, bv, 0, "R1 R2 skip slot");
    if (!taken) done_chk(1, "R3");
    if (bub) bubble(taken);
    for (int i = 0; i < k; i++)
      slot((i % 2 == 0) ? 3'd5 : 3'd6, 1'b0, 1'b0, taken, "R5 prefix");
    slot(3'd0, 1'b0, 1'b0, taken, k == 0 ? "R4 plain" : "R5 tail");
    if (taken) begin
      exp_len = (k + 2 > LMAX) ? LMAX : k + 2;
      done_chk(exp_len, k > LMAX - 2 ? "R9" : (k == 0 ? "R4" : "R5"));
    end
    slot(3'd0, 1'b0, 1'b0, 0, "R3 R4 after skip");
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk("R8 reset busy", busy, 0);
    chk("R8 reset annul", annul, 0);
    chk("R8 reset done", skip_done, 0);
    chk("R8 reset len", skip_len, 0);
    rst_n = 1'b1;
    for (int sc = 1; sc <= 4; sc++)
      for (int cv = 0; cv < 2; cv++)
        for (int k = 0; k <= 3; k++)
          for (int b = 0; b < 2; b++)
            run(sc, cv[0], k, b[0]);
    run(1, 1'b1, 20, 1'b0);
    slot(3'd2, 1'b1, 1'b0, 0, "R8 skip before reset");
    @(negedge clk); rst_n = 1'b0; slot_vld = 1'b0;
    @(negedge clk); rst_n = 1'b1; #1;
    chk("R8 reset clears busy", busy, 0);
    slot(3'd0, 1'b0, 1'b0, 0, "R8 no annul after reset");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule